// File: doc/BRIEF.md
# PHY Test-Port Register Write Sequencer

This block writes one 8-bit configuration register inside a receive PHY through the PHY's serial test port. A requester presents an 8-bit register code and an 8-bit value with a single-cycle request. The block then plays a fixed strobe pattern on four outputs: a clear line, a test clock, a test-enable line and an 8-bit test bus. Each step of the pattern is held for `PHASE_CYCLES` system-clock cycles.

The pattern has six steps. First comes a clear pulse, then a release with everything low. The test clock is then raised with enable low. Enable is then raised with the code on the bus while the clock falls, so the PHY takes the code on that falling edge. Enable is then lowered with the value on the bus while the clock rises, so the PHY takes the value on that rising edge. Last, the clock is lowered and everything is left at zero. A typical use is writing the high-speed frequency-range selector, which sits at code 0x44. `busy` is high for the whole pattern. `done` pulses once at the end. The block is idle again in that same cycle, so a new request can be accepted there.

Top module: `phy_test_writer`

## Requirements
- R1: While `rstN` is low at a clock edge, the block goes idle after that edge: `busy`, `done`, `testClr`, `testClk`, `testEn` low and `testData` zero. This holds even in the middle of a write.
- R2: A request (`reqValid` high while `busy` is low) sampled at an edge makes `busy` high from that edge for exactly 6×`PHASE_CYCLES` cycles.
- R3: The first `PHASE_CYCLES` busy cycles have `testClr`=1 with clock, enable and bus at zero. The next `PHASE_CYCLES` cycles have all four test outputs at zero.
- R4: The third group of `PHASE_CYCLES` cycles has `testClk`=1 with `testEn`=0 and `testData`=0.
- R5: The fourth group has `testEn`=1, `testClk`=0 and `testData` equal to the request's code. Enable therefore rises in the same cycle that the clock falls.
- R6: The fifth group has `testEn`=0, `testClk`=1 and `testData` equal to the request's value. Enable therefore falls in the same cycle that the clock rises.
- R7: The sixth group has all test outputs at zero with `busy` still high. In the cycle after that group, `busy` is low and `done` is high for exactly one cycle.
- R8: `reqValid` is ignored while `busy` is high. The code, value and timing of the write in progress are unchanged.
- R9: `testEn` and `testClk` are never high in the same cycle. `testClr` is never high together with any other test output.
- R10: A request sampled in the cycle where `done` is high is accepted, so writes can run back to back with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled when idle |
| reqCode | input | 8 | PHY register code to write |
| reqData | input | 8 | Value to write to that register |
| busy | output | 1 | High while a write pattern is running |
| done | output | 1 | One-cycle pulse after the pattern ends |
| testClr | output | 1 | PHY test-port clear |
| testClk | output | 1 | PHY test-port clock |
| testEn | output | 1 | PHY test-port enable (high selects code capture) |
| testData | output | 8 | PHY test-port data bus |

## Verification
The assertions check, on every cycle, the properties that need no count of phase length. These are the mutual exclusion of enable, clock and clear, zero outputs while idle, the one-cycle `done` after `busy`, entry into the clear step on an accepted request, and enable rising exactly as the clock falls and falling exactly as it rises. Only the bench's reference model can show that each step lasts exactly `PHASE_CYCLES` cycles and that the bus carries the code and then the value of the request that was accepted. The bench scenarios also show that requests held during a write are dropped, that a request in the `done` cycle starts at once, and that a reset in the middle of a write abandons it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CLEAR   = 3'd1,
    PH_RELEASE = 3'd2,
    PH_CLKHI   = 3'd3,
    PH_CODE    = 3'd4,
    PH_DATA    = 3'd5,
    PH_CLKLO   = 3'd6
  } phase_e;

  typedef struct packed {
    logic   capture;
    phase_e nextPhase;
  } strobe_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int PHASE_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    busy,
  output logic    done,
  output strobe_t strobes
);
  localparam int CNT_W  = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam int LAST_I = PHASE_CYCLES - 1;
  localparam logic [CNT_W-1:0] LAST_CNT = LAST_I[CNT_W-1:0];

  phase_e          phaseQ, phaseD;
  logic [CNT_W-1:0] tickQ, tickD;
  logic             lastTick;
  logic             finish;
  logic             doneQ;

  assign lastTick = (tickQ == LAST_CNT);

  always_comb begin
    phaseD  = phaseQ;
    finish  = 1'b0;
    strobes = '{capture: 1'b0, nextPhase: phaseQ};
    if (phaseQ == PH_IDLE) begin
      if (reqValid) begin
        phaseD          = PH_CLEAR;
        strobes.capture = 1'b1;
      end
    end else if (lastTick) begin
      unique case (phaseQ)
        PH_CLEAR:   phaseD = PH_RELEASE;
        PH_RELEASE: phaseD = PH_CLKHI;
        PH_CLKHI:   phaseD = PH_CODE;
        PH_CODE:    phaseD = PH_DATA;
        PH_DATA:    phaseD = PH_CLKLO;
        default: begin
          phaseD = PH_IDLE;
          finish = 1'b1;
        end
      endcase
    end
    strobes.nextPhase = phaseD;
    tickD = (phaseD != phaseQ) ? '0 : tickQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      tickQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      tickQ  <= (phaseD == PH_IDLE) ? '0 : tickD;
      doneQ  <= finish;
    end
  end

  assign busy = (phaseQ != PH_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [BYTE_W-1:0] reqCode,
  input  logic [BYTE_W-1:0] reqData,
  output logic              testClr,
  output logic              testClk,
  output logic              testEn,
  output logic [BYTE_W-1:0] testData
);
  logic [BYTE_W-1:0] codeQ, valueQ;
  logic              clrD, clkD, enD;
  logic [BYTE_W-1:0] busD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ  <= '0;
      valueQ <= '0;
    end else if (strobes.capture) begin
      codeQ  <= reqCode;
      valueQ <= reqData;
    end
  end

  always_comb begin
    clrD = 1'b0;
    clkD = 1'b0;
    enD  = 1'b0;
    busD = '0;
    unique case (strobes.nextPhase)
      PH_CLEAR: clrD = 1'b1;
      PH_CLKHI: clkD = 1'b1;
      PH_CODE: begin
        enD  = 1'b1;
        busD = codeQ;
      end
      PH_DATA: begin
        clkD = 1'b1;
        busD = valueQ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testClr  <= 1'b0;
      testClk  <= 1'b0;
      testEn   <= 1'b0;
      testData <= '0;
    end else begin
      testClr  <= clrD;
      testClk  <= clkD;
      testEn   <= enD;
      testData <= busD;
    end
  end
endmodule

// File: rtl/phy_test_writer.sv
module phy_test_writer
  import ptw_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int PHASE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BYTE_W-1:0] reqCode,
  input  logic [BYTE_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic              testClr,
  output logic              testClk,
  output logic              testEn,
  output logic [BYTE_W-1:0] testData
);
  strobe_t strobes;

  ptw_ctrl #(.PHASE_CYCLES(PHASE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busy     (busy),
    .done     (done),
    .strobes  (strobes)
  );

  ptw_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqCode  (reqCode),
    .reqData  (reqData),
    .testClr  (testClr),
    .testClk  (testClk),
    .testEn   (testEn),
    .testData (testData)
  );
endmodule

// File: rtl/phy_test_writer_chk.sv
module phy_test_writer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic              testClr,
  input logic              testClk,
  input logic              testEn,
  input logic [BYTE_W-1:0] testData
);
  AST_EN_CLK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(testEn && testClk)); // R9
  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    testClr |-> (!testClk && !testEn && testData == '0)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!testClr && !testClk && !testEn && testData == '0)); // R7
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(rstN)) |-> (!busy && $past(busy))); // R7
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> (busy && testClr)); // R2
  AST_CODE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(testEn) && $past(rstN)) |-> $fell(testClk)); // R5
  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(testEn) && $past(rstN)) |-> $rose(testClk)); // R6
endmodule

bind phy_test_writer phy_test_writer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done),
  .testClr  (testClr),
  .testClk  (testClk),
  .testEn   (testEn),
  .testData (testData)
);

// File: tb/phy_test_writer_tb.sv
module phy_test_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic       busy;
    logic       done;
    logic       clr;
    logic       tclk;
    logic       en;
    logic [7:0] data;
    logic [2:0] ph;   // 0 idle, 1..6 pattern step, 7 done cycle
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqCode = '0;
  logic [7:0] reqData = '0;
  logic       busy, done, testClr, testClk, testEn;
  logic [7:0] testData;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  bit    started = 1'b0;
  string scen = "R1";
  exp_t  expQ[$];
  exp_t  cur = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_test_writer #(.BYTE_W(8), .PHASE_CYCLES(N)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode),
    .reqData(reqData), .busy(busy), .done(done), .testClr(testClr),
    .testClk(testClk), .testEn(testEn), .testData(testData)
  );

  function automatic exp_t mk(logic b, logic d, logic c, logic k, logic e,
                              logic [7:0] v, logic [2:0] p);
    exp_t x;
    x.busy = b; x.done = d; x.clr = c; x.tclk = k; x.en = e; x.data = v; x.ph = p;
    return x;
  endfunction

  // Behavioural reference: a queue of expected per-cycle output vectors
  always @(posedge clk) begin
    started = 1'b1;
    cycles++;
    if (!rstN) begin
      expQ.delete();
      cur = '0;
    end else begin
      if (!cur.busy && reqValid) begin
        for (int i = 0; i < N; i++) expQ.push_back(mk(1, 0, 1, 0, 0, 8'h00, 3'd1));
        for (int i = 0; i < N; i++) expQ.push_back(mk(1, 0, 0, 0, 0, 8'h00, 3'd2));
        for (int i = 0; i < N; i++) expQ.push_back(mk(1, 0, 0, 1, 0, 8'h00, 3'd3));
        for (int i = 0; i < N; i++) expQ.push_back(mk(1, 0, 0, 0, 1, reqCode, 3'd4));
        for (int i = 0; i < N; i++) expQ.push_back(mk(1, 0, 0, 1, 0, reqData, 3'd5));
        for (int i = 0; i < N; i++) expQ.push_back(mk(1, 0, 0, 0, 0, 8'h00, 3'd6));
        expQ.push_back(mk(0, 1, 0, 0, 0, 8'h00, 3'd7));
      end
      cur = (expQ.size() > 0) ? expQ.pop_front() : '0;
    end
  end

  function automatic string tagOf(logic [2:0] p);
    case (p)
      3'd1, 3'd2: return "R3";
      3'd3:       return "R4";
      3'd4:       return "R5";
      3'd5:       return "R6";
      3'd6, 3'd7: return "R7";
      default:    return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started) begin
      exp_t act;
      act = mk(busy, done, testClr, testClk, testEn, testData, cur.ph);
      vectors++;
      if (act !== cur) begin
        miscompares++;
        $display("FAIL %s (scenario %s) t=%0t act busy=%b done=%b clr=%b clk=%b en=%b data=%02h exp busy=%b done=%b clr=%b clk=%b en=%b data=%02h",
                 tagOf(cur.ph), scen, $time, busy, done, testClr, testClk, testEn, testData,
                 cur.busy, cur.done, cur.clr, cur.tclk, cur.en, cur.data);
      end
      if (testEn && testClk) begin  // R9 seen at the ports
        miscompares++;
        $display("FAIL R9 act en=%b clk=%b exp not both high", testEn, testClk);
      end
    end
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog act cycles=%0d exp <= %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic waitNeg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(logic [7:0] c, logic [7:0] d, int hold);
    reqCode  = c;
    reqData  = d;
    reqValid = 1'b1;
    waitNeg(hold);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    waitNeg(1);
    while (busy || done) waitNeg(1);
    waitNeg(2);
  endtask

  initial begin
    scen = "R1";
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(2);

    scen = "R2";      // frequency-range selector write
    issue(8'h44, 8'h2a, 1);
    waitIdle();

    scen = "R5";      // all-ones code, all-zero value
    issue(8'hff, 8'h00, 1);
    waitIdle();

    scen = "R6";      // alternating patterns
    issue(8'ha5, 8'h5a, 1);
    waitIdle();

    scen = "R8";      // request held through the write with changing fields
    reqCode = 8'h11; reqData = 8'h22; reqValid = 1'b1;
    waitNeg(1);
    for (int i = 0; i < 5 * N; i++) begin
      reqCode = reqCode + 8'h13;
      reqData = reqData ^ 8'hc3;
      waitNeg(1);
    end
    reqValid = 1'b0;
    waitIdle();

    scen = "R10";     // request held high: re-accepted in the done cycle
    reqCode = 8'h3c; reqData = 8'hc3; reqValid = 1'b1;
    waitNeg(6 * N + 3);
    reqCode = 8'h44; reqData = 8'h01;
    waitNeg(2);
    reqValid = 1'b0;
    waitIdle();

    scen = "R1";      // reset in the middle of the code step
    issue(8'h77, 8'h88, 1);
    waitNeg(3 * N + 1);
    rstN = 1'b0;
    waitNeg(2);
    rstN = 1'b1;
    waitNeg(2);

    scen = "R3";      // clean write after the abandoned one
    issue(8'h01, 8'h80, 1);
    waitIdle();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule